// File: doc/BRIEF.md
# I2C Line Control and Module Reset Register

This block is the line-control register of an I2C controller. One 8-bit register holds a controller enable, an internal reset for the transfer logic, and two software-owned output levels for SCL and SDA. The output levels can be changed only by a write that also clears a guard bit. The same register returns the present, synchronized levels of both bus lines. A bus-recovery routine in software can therefore clock SCL by hand and watch SDA without help from the transfer engine.

The block drives the two open-drain pull-down enables for the pads. Each line is pulled low when the controller is enabled and either its software level is 0 or, outside internal reset, the transfer engine asks for it. Toward the engine it provides the synchronized line levels, a bus-busy flag, and the internal-reset request. Bus-busy is set by a detected start condition and cleared by a detected stop. It does not show that the lines are idle, because SDA can stay low without any start having been seen.

Start-up follows a fixed order: internal reset is set with enable still clear, then enable is set, then internal reset is released. An attempt to turn enable on while internal reset is not already set is dropped.

Top module: `i2c_line_ctrl`

## Requirements
- R1: After reset the register reads 8'h1F. Enable (bit 7) and internal reset (bit 6) are 0, bit 5 reads 0, the guard bit (bit 4) reads 1, both level bits (bit 3 SCL, bit 2 SDA) are 1, and both sampled-line bits (bit 1 SCL, bit 0 SDA) are 1. Bus-busy and both pull outputs are 0.
- R2: A write updates the SCL level (bit 3) and the SDA level (bit 2) only when bit 4 of the written value is 0. With bit 4 at 1, both level bits keep their values.
- R3: Internal reset (bit 6) takes the written value on every write. Enable (bit 7) may be cleared by any write. It changes from 0 to 1 only if internal reset was already 1 before that write; otherwise it stays 0.
- R4: While enable is 0, neither pull output is asserted, whatever the level bits and engine requests are.
- R5: While enable is 1, a line's pull output is asserted when its level bit is 0, or when the engine requests that line and internal reset is 0.
- R6: While internal reset is 1, engine pull requests have no effect, core_rst_o is 1, and bus-busy is cleared on the next clock edge.
- R7: Bits 1 and 0 of the register, and scl_line_o and sda_line_o, show the pad inputs delayed by SYNC_STAGES clock edges.
- R8: Bus-busy becomes 1 one edge after the synchronized SDA falls while synchronized SCL is high (start). It becomes 0 one edge after the synchronized SDA rises while SCL is high (stop). Otherwise it holds its value.
- R9: When SDA goes low while SCL is low, bus-busy stays 0 while the synchronized SDA reads 0.
- R10: Bit 5 always reads 0 and bit 4 always reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| scl_pad_i | input | 1 | Raw SCL pad level |
| sda_pad_i | input | 1 | Raw SDA pad level |
| eng_scl_pull_i | input | 1 | Transfer engine asks for SCL low |
| eng_sda_pull_i | input | 1 | Transfer engine asks for SDA low |
| scl_pull_o | output | 1 | Open-drain pull-down enable for SCL |
| sda_pull_o | output | 1 | Open-drain pull-down enable for SDA |
| scl_line_o | output | 1 | Synchronized SCL level to the engine |
| sda_line_o | output | 1 | Synchronized SDA level to the engine |
| bus_busy_o | output | 1 | Bus-busy flag to the engine |
| core_rst_o | output | 1 | Internal reset request to the engine |

## Verification
The bench builds the block with SYNC_STAGES set to 3 instead of the default 2. With that setting, any latency hard-wired to two stages in the synchronizer or in the start/stop detector shows up as a mismatch against the reference model. The pad patterns cover a start, a stop, and SDA dropping while SCL is low, so the flag is seen in all three situations. A pseudo-random phase mixes register writes, engine requests and line toggles, so the enable-ordering rule and the guard bit are tested against lines that keep moving.

// File: rtl/i2c_lc_pkg.sv
package i2c_lc_pkg;
    localparam int REG_W    = 8;
    localparam int B_EN     = 7;
    localparam int B_RST    = 6;
    localparam int B_RSVD   = 5;
    localparam int B_GUARD  = 4;
    localparam int B_SCLLVL = 3;
    localparam int B_SDALVL = 2;
    localparam int B_SCLIN  = 1;
    localparam int B_SDAIN  = 0;

    typedef struct packed {
        logic en;
        logic rst;
        logic scl_lvl;
        logic sda_lvl;
    } lc_reg_t;

    typedef struct packed {
        logic busy;
        logic sda_prev;
    } busdet_t;
endpackage

// File: rtl/i2c_lc_sync.sv
module i2c_lc_sync #(
    parameter int       STAGES  = 2,
    parameter int       W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_chain
        always_comb begin
            stage_d[i] = stage_q[i-1];
        end
    end

    for (genvar i = 0; i < STAGES; i++) begin : g_regs
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= RST_VAL;
            else        stage_q[i] <= stage_d[i];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_lc_busdet.sv
module i2c_lc_busdet
    import i2c_lc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic scl_s,
    input  logic sda_s,
    output logic busy
);
    busdet_t st_d, st_q;
    logic    start_ev, stop_ev;

    always_comb begin
        start_ev = scl_s && st_q.sda_prev && !sda_s;
        stop_ev  = scl_s && !st_q.sda_prev && sda_s;
        st_d          = st_q;
        st_d.sda_prev = sda_s;
        if (hold)          st_d.busy = 1'b0;
        else if (start_ev) st_d.busy = 1'b1;
        else if (stop_ev)  st_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{busy: 1'b0, sda_prev: 1'b1};
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;

    // R6: internal reset clears the flag on the next edge
    a_r6_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !busy);
    // R8: the flag only rises after a start pattern on the synchronized lines
    a_r8_rise_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        !busy ##1 busy |-> $past(scl_s) && !$past(sda_s));
endmodule

// File: rtl/i2c_lc_ctrlreg.sv
module i2c_lc_ctrlreg
    import i2c_lc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output lc_reg_t          cfg
);
    lc_reg_t cfg_d, cfg_q;
    logic    en_req;
    logic    unused_rsvd;

    assign unused_rsvd = wr_data[B_RSVD] ^ wr_data[B_SCLIN] ^ wr_data[B_SDAIN];

    always_comb begin
        cfg_d  = cfg_q;
        en_req = wr_data[B_EN];
        if (wr_en) begin
            cfg_d.rst = wr_data[B_RST];
            cfg_d.en  = en_req && (cfg_q.en || cfg_q.rst);
            if (!wr_data[B_GUARD]) begin
                cfg_d.scl_lvl = wr_data[B_SCLLVL];
                cfg_d.sda_lvl = wr_data[B_SDALVL];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{en: 1'b0, rst: 1'b0, scl_lvl: 1'b1, sda_lvl: 1'b1};
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R3: enable only rises when internal reset was already set
    a_r3_enable_order: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.en ##1 cfg_q.en |-> $past(cfg_q.rst));
    // R2: a guarded write leaves the level bits alone
    a_r2_guard_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[B_GUARD]) |=>
            (cfg_q.scl_lvl == $past(cfg_q.scl_lvl)) && (cfg_q.sda_lvl == $past(cfg_q.sda_lvl)));
    // R3: no enable change without a write
    a_r3_no_spont: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q.en));
endmodule

// File: rtl/i2c_line_ctrl.sv
module i2c_line_ctrl
    import i2c_lc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             scl_pad_i,
    input  logic             sda_pad_i,
    input  logic             eng_scl_pull_i,
    input  logic             eng_sda_pull_i,
    output logic             scl_pull_o,
    output logic             sda_pull_o,
    output logic             scl_line_o,
    output logic             sda_line_o,
    output logic             bus_busy_o,
    output logic             core_rst_o
);
    localparam int LINES = 2;

    lc_reg_t          cfg;
    logic [LINES-1:0] line_s;
    logic             eng_ok;

    i2c_lc_ctrlreg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    i2c_lc_sync #(
        .STAGES  (SYNC_STAGES),
        .W       (LINES),
        .RST_VAL ('1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_pad_i, sda_pad_i}),
        .dout  (line_s)
    );

    i2c_lc_busdet u_busdet (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (cfg.rst),
        .scl_s (line_s[1]),
        .sda_s (line_s[0]),
        .busy  (bus_busy_o)
    );

    always_comb begin
        eng_ok     = !cfg.rst;
        scl_pull_o = cfg.en && (!cfg.scl_lvl || (eng_ok && eng_scl_pull_i));
        sda_pull_o = cfg.en && (!cfg.sda_lvl || (eng_ok && eng_sda_pull_i));
        rd_data          = '0;
        rd_data[B_EN]     = cfg.en;
        rd_data[B_RST]    = cfg.rst;
        rd_data[B_RSVD]   = 1'b0;
        rd_data[B_GUARD]  = 1'b1;
        rd_data[B_SCLLVL] = cfg.scl_lvl;
        rd_data[B_SDALVL] = cfg.sda_lvl;
        rd_data[B_SCLIN]  = line_s[1];
        rd_data[B_SDAIN]  = line_s[0];
    end

    assign scl_line_o = line_s[1];
    assign sda_line_o = line_s[0];
    assign core_rst_o = cfg.rst;

    // R4: no pad pull while disabled
    a_r4_off_no_pull: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[B_EN] |-> !scl_pull_o && !sda_pull_o);
    // R6: engine requests are masked during internal reset
    a_r6_eng_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst_o && rd_data[B_SCLLVL]) |-> !scl_pull_o);
endmodule

// File: tb/i2c_line_ctrl_tb.sv
module i2c_line_ctrl_tb;
    localparam int SYNC = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       scl_pad = 1'b1, sda_pad = 1'b1;
    logic       eng_scl = 1'b0, eng_sda = 1'b0;
    logic       scl_pull, sda_pull, scl_line, sda_line, busy, core_rst;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit cmp_on = 0;
    int cyc = 0;

    // reference state
    bit m_en, m_rst, m_scl, m_sda, m_busy, m_prev;
    bit hs [SYNC];
    bit hd [SYNC];

    always #5 clk = ~clk;

    i2c_line_ctrl #(.SYNC_STAGES(SYNC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .scl_pad_i(scl_pad), .sda_pad_i(sda_pad),
        .eng_scl_pull_i(eng_scl), .eng_sda_pull_i(eng_sda),
        .scl_pull_o(scl_pull), .sda_pull_o(sda_pull),
        .scl_line_o(scl_line), .sda_line_o(sda_line),
        .bus_busy_o(busy), .core_rst_o(core_rst)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_rst = 0; m_scl = 1; m_sda = 1; m_busy = 0; m_prev = 1;
            for (int i = 0; i < SYNC; i++) begin hs[i] = 1; hd[i] = 1; end
        end else begin
            bit sc, sd;
            sc = hs[SYNC-1]; sd = hd[SYNC-1];
            if (m_rst) m_busy = 0;
            else if (sc && m_prev && !sd) m_busy = 1;
            else if (sc && !m_prev && sd) m_busy = 0;
            m_prev = sd;
            for (int i = SYNC-1; i > 0; i--) begin hs[i] = hs[i-1]; hd[i] = hd[i-1]; end
            hs[0] = scl_pad; hd[0] = sda_pad;
            if (wr_en) begin
                m_en = wr_data[7] && (m_en || m_rst);
                m_rst = wr_data[6];
                if (!wr_data[4]) begin m_scl = wr_data[3]; m_sda = wr_data[2]; end
            end
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            bit xs, xd;
            xs = m_en && (!m_scl || (!m_rst && eng_scl));
            xd = m_en && (!m_sda || (!m_rst && eng_sda));
            chk("R3 en/rst bits", {6'd0, rd_data[7:6]}, {6'd0, m_en, m_rst});
            chk("R10 fixed bits", {6'd0, rd_data[5:4]}, 8'h01);
            chk("R2 level bits", {6'd0, rd_data[3:2]}, {6'd0, m_scl, m_sda});
            chk("R7 sampled lines", {4'd0, rd_data[1:0], scl_line, sda_line},
                {4'd0, hs[SYNC-1], hd[SYNC-1], hs[SYNC-1], hd[SYNC-1]});
            chk(m_en ? "R5 pulls" : "R4 pulls", {6'd0, scl_pull, sda_pull}, {6'd0, xs, xd});
            chk("R8 busy", {7'd0, busy}, {7'd0, m_busy});
            chk("R6 core reset", {7'd0, core_rst}, {7'd0, m_rst});
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
    endtask

    task automatic wr(input logic [7:0] v);
        @(posedge clk); #2 wr_en = 1; wr_data = v;
        @(posedge clk); #2 wr_en = 0;
    endtask

    task automatic pads(input logic c, input logic d);
        @(posedge clk); #2 scl_pad = c; sda_pad = d;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        step(3);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R1 reset value", rd_data, 8'h1F);
        chk("R1 reset outputs", {5'd0, busy, scl_pull, sda_pull}, 8'h00);
        cmp_on = 1;
        // R2: guarded write keeps levels, unguarded write changes them
        wr(8'h10); step(1);
        chk("R2 guarded write", {6'd0, rd_data[3:2]}, 8'h03);
        wr(8'h00); step(1);
        chk("R2 open write", {6'd0, rd_data[3:2]}, 8'h00);
        wr(8'h1C); step(1);
        chk("R2 guarded keeps zero", {6'd0, rd_data[3:2]}, 8'h00);
        // R4: disabled, levels at 0, engine asking: no pull
        eng_scl = 1; eng_sda = 1; step(2);
        chk("R4 no pull when off", {6'd0, scl_pull, sda_pull}, 8'h00);
        wr(8'h0C);
        // R3: enable without prior reset is dropped
        wr(8'h9C); step(1);
        chk("R3 enable refused", {7'd0, rd_data[7]}, 8'h00);
        wr(8'hDC); step(1);
        chk("R3 enable refused same write", {7'd0, rd_data[7]}, 8'h00);
        wr(8'hDC); step(1);
        chk("R3 enable accepted", {6'd0, rd_data[7:6]}, 8'h03);
        // R6: engine masked during reset
        chk("R6 engine masked", {6'd0, scl_pull, sda_pull}, 8'h00);
        wr(8'h9C); step(1);
        chk("R5 engine pulls", {6'd0, scl_pull, sda_pull}, 8'h03);
        eng_scl = 0; eng_sda = 0;
        wr(8'h88); step(1);
        chk("R5 level pull sda", {6'd0, scl_pull, sda_pull}, 8'h01);
        wr(8'h8C);
        // R8: start then stop
        pads(1, 0); step(SYNC + 1);
        chk("R8 start sets busy", {7'd0, busy}, 8'h01);
        pads(1, 1); step(SYNC + 1);
        chk("R8 stop clears busy", {7'd0, busy}, 8'h00);
        // R9: SDA low with SCL low: no start
        pads(0, 1); step(1); pads(0, 0); step(SYNC + 2);
        chk("R9 busy low while sda low", {6'd0, busy, sda_line}, 8'h00);
        pads(1, 0); step(SYNC + 2);
        chk("R9 still not busy", {7'd0, busy}, 8'h00);
        pads(1, 1); step(SYNC + 1); pads(1, 0); step(SYNC + 1);
        chk("R8 busy before hold", {7'd0, busy}, 8'h01);
        wr(8'hCC); step(1);
        chk("R6 reset clears busy", {7'd0, busy}, 8'h00);
        wr(8'h0C); pads(1, 1); step(SYNC + 1);
        chk("R4 disable clears pulls", {6'd0, scl_pull, sda_pull}, 8'h00);
        // mixed phase
        lfsr = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            @(posedge clk); #2;
            scl_pad = lfsr[0] | lfsr[5];
            sda_pad = lfsr[1];
            eng_scl = lfsr[2];
            eng_sda = lfsr[3];
            wr_en = (lfsr[7:4] == 4'h3);
            wr_data = {lfsr[15:8]};
        end
        @(posedge clk); #2 wr_en = 0;
        step(4);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule